// File: doc/BRIEF.md
# Slave Host Interface Register Block

This block sits between an 8-bit host bus and the local core of a slave peripheral controller. The host writes bytes into an input buffer, reads bytes from an output buffer, and reads a status byte. On every host write, the address bit is recorded in the status byte, so the local core can tell command bytes from data bytes. The local core empties the input buffer, fills the output buffer, and sets the upper status bits and one local flag through a simple register port.

Input-full and output-full flags change only when a host strobe ends, never when it starts. While the host reads the status byte, the value it sees does not move. Two optional pins can signal the host when a buffer needs service. They are gated by a small port latch after a flags-enable command. After a DMA-enable command, the latch drives a DMA request pin, and the acknowledge input acts as a select for the data buffers. Any host strobe made under acknowledge clears the request.

All host inputs are sampled on the block clock. An access is one or more cycles with a strobe high while the block is selected. It is committed on the first cycle with the strobe low.

Top module: `host_slave_if`

## Requirements
- R1: After reset, the status byte is 0x00, all three service pins are low, the port latch is 0 and the host bus is not driven (`hostRdEn` low).
- R2: A host write latches `hostWdata` and the address bit. On the clock edge after the strobe ends, the input buffer takes the data, IBF (status bit 1) becomes 1 and F1 (status bit 3) takes the address bit (1 = command, 0 = data).
- R3: A `locInRd` pulse clears IBF on the next clock edge. A host write completing in the same cycle wins.
- R4: A `locOutWr` pulse loads the output buffer and sets OBF (status bit 0). OBF clears when a host read of the output buffer (address 0) ends. A host read of the status byte leaves OBF set.
- R5: A `locStsWr` pulse copies `locStsUser` into status bits 7..4 and leaves bits 3..0 unchanged.
- R6: While the block is selected and `hostRd` is high, `hostRdEn` is high. `hostRdata` then shows the status byte for address 1 and the output buffer for address 0. Otherwise `hostRdata` is 0. The status byte the host sees lags local changes by one cycle. Its layout is {bits 7..4 user, F1, F0, IBF, OBF}.
- R7: IBF, OBF and F1 do not change while a host strobe is still high.
- R8: While a host status read is in progress, `hostRdata` stays constant even when local writes change the status.
- R9: Before `locFlagsCmd`, `pinObf` and `pinIbf` follow port latch bits 0 and 1. After it, `pinObf` = latch bit 0 AND OBF, and `pinIbf` = latch bit 1 AND NOT IBF.
- R10: Before `locDmaCmd`, `pinDrq` follows latch bit 2. After it, a `locPortWr` with bit 2 set raises `pinDrq`. A host access under acknowledge clears the request when it ends, and so does another `locDmaCmd`.
- R11: In DMA mode, `dmaAck` selects the data buffers with the address forced to 0. Outside DMA mode, `dmaAck` is ignored: it neither drives the bus nor loads the buffer.
- R12: F0 (status bit 2) changes only through `locF0Wr`. Host writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hostSel | input | 1 | Host chip select, active high |
| hostAddr | input | 1 | Host address bit: 1 = command/status, 0 = data |
| hostRd | input | 1 | Host read strobe, active high |
| hostWr | input | 1 | Host write strobe, active high |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Host read data (0 when not driven) |
| hostRdEn | output | 1 | Host bus drive enable |
| dmaAck | input | 1 | DMA acknowledge, acts as data select in DMA mode |
| pinObf | output | 1 | Output-full service pin / port bit 0 |
| pinIbf | output | 1 | Input-ready service pin / port bit 1 |
| pinDrq | output | 1 | DMA request pin / port bit 2 |
| locInRd | input | 1 | Local unload pulse for the input buffer |
| locInData | output | 8 | Input buffer contents |
| locOutWr | input | 1 | Local load pulse for the output buffer |
| locOutData | input | 8 | Data for the output buffer |
| locStsWr | input | 1 | Local status user-bits write pulse |
| locStsUser | input | 4 | New value for status bits 7..4 |
| locF0Wr | input | 1 | Local F0 write pulse |
| locF0Val | input | 1 | New F0 value |
| locFlagsCmd | input | 1 | Flags-enable command pulse |
| locDmaCmd | input | 1 | DMA-enable command pulse |
| locPortWr | input | 1 | Port latch write pulse |
| locPortData | input | 3 | New port latch value |
| locStatus | output | 8 | Live status byte for the local core |

## Verification
Host writes are tried with one-cycle and three-cycle strobes, using both address values. The long strobe shows whether flags move at the end of the strobe rather than the start, and the two addresses show whether F1 really comes from the address bit. Host reads target status and data separately, which shows whether only a data read empties the output buffer. A status read held across local writes shows whether the host view is frozen. Acknowledge-driven transfers are run with DMA mode both off and on, using a host address of 1. This shows whether acknowledge is ignored outside DMA mode and forces a data access inside it. The request pin is cleared both by a transfer and by a repeated command.

// File: rtl/hsi_pkg.sv
package hsi_pkg;
  // strobes handed from the control to the datapath each cycle
  typedef struct packed {
    logic capWr;         // host write strobe active: shadow data/address
    logic rdAct;         // host read active: drive the bus
    logic commitWr;      // write strobe just ended
    logic commitRdData;  // read of the output buffer just ended
    logic stsRead;       // host is reading the status byte
    logic effAddr;       // effective address (0 when selected by acknowledge)
  } hsiStrobe_t;

  localparam int FLAG_W = 4;  // F1, F0, IBF, OBF
  localparam int OBF_POS = 0;
  localparam int IBF_POS = 1;
  localparam int F0_POS  = 2;
  localparam int F1_POS  = 3;
endpackage

// File: rtl/hsi_ctrl.sv
module hsi_ctrl
  import hsi_pkg::*;
#(
  parameter int LATCH_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hostSel,
  input  logic               hostAddr,
  input  logic               hostRd,
  input  logic               hostWr,
  input  logic               dmaAck,
  input  logic               flagsCmd,
  input  logic               dmaCmd,
  input  logic               portWr,
  input  logic [LATCH_W-1:0] portData,
  output hsiStrobe_t         strb,
  output logic               flagsMode,
  output logic               dmaMode,
  output logic               drq,
  output logic [LATCH_W-1:0] portLatch
);
  localparam int DRQ_BIT = 2;

  logic ackSel, selEff, effAddr, wrAct, rdAct;
  logic wrActQ, rdActQ, rdAddrQ, wrAckQ, rdAckQ;
  logic commitWr, commitRd, drqSet, drqClr;

  assign ackSel  = dmaMode & dmaAck;
  assign selEff  = hostSel | ackSel;
  assign effAddr = hostSel ? hostAddr : 1'b0;
  assign wrAct   = selEff & hostWr;
  assign rdAct   = selEff & hostRd;

  assign commitWr = wrActQ & ~wrAct;
  assign commitRd = rdActQ & ~rdAct;

  assign drqSet = dmaMode & portWr & portData[DRQ_BIT];
  assign drqClr = dmaCmd | (commitWr & wrAckQ) | (commitRd & rdAckQ);

  always_comb begin
    strb.capWr        = wrAct;
    strb.rdAct        = rdAct;
    strb.commitWr     = commitWr;
    strb.commitRdData = commitRd & ~rdAddrQ;
    strb.stsRead      = rdAct & effAddr;
    strb.effAddr      = effAddr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrActQ    <= 1'b0;
      rdActQ    <= 1'b0;
      rdAddrQ   <= 1'b0;
      wrAckQ    <= 1'b0;
      rdAckQ    <= 1'b0;
      flagsMode <= 1'b0;
      dmaMode   <= 1'b0;
      drq       <= 1'b0;
      portLatch <= '0;
    end else begin
      wrActQ <= wrAct;
      rdActQ <= rdAct;
      if (wrAct) wrAckQ <= ackSel & ~hostSel;
      if (rdAct) begin
        rdAddrQ <= effAddr;
        rdAckQ  <= ackSel & ~hostSel;
      end
      if (flagsCmd) flagsMode <= 1'b1;
      if (dmaCmd)   dmaMode   <= 1'b1;
      if (portWr)   portLatch <= portData;
      if (drqClr)      drq <= 1'b0;
      else if (drqSet) drq <= 1'b1;
    end
  end

  // R10: a repeated DMA-enable command always drops the request
  a_r10_cmd_clears_drq : assert property (@(posedge clk) disable iff (!rst_n)
    dmaCmd |=> !drq);

  // R11: without DMA mode, acknowledge alone never starts an access
  a_r11_ack_ignored : assert property (@(posedge clk) disable iff (!rst_n)
    (!dmaMode && !hostSel) |-> (!strb.capWr && !strb.rdAct));

  // R7: a commit is only seen after the strobe was active
  a_r7_commit_after_strobe : assert property (@(posedge clk) disable iff (!rst_n)
    strb.commitWr |-> !hostWr || !selEff);
endmodule

// File: rtl/hsi_datapath.sv
module hsi_datapath
  import hsi_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  hsiStrobe_t        strb,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  input  logic              locInRd,
  output logic [DATA_W-1:0] locInData,
  input  logic              locOutWr,
  input  logic [DATA_W-1:0] locOutData,
  input  logic              locStsWr,
  input  logic [DATA_W-FLAG_W-1:0] locStsUser,
  input  logic              locF0Wr,
  input  logic              locF0Val,
  output logic [DATA_W-1:0] liveSts
);
  localparam int USER_W = DATA_W - FLAG_W;

  logic [DATA_W-1:0] wrShadow, inBuf, outBuf, stsView;
  logic              addrShadow;
  logic [USER_W-1:0] userBits;
  logic              f1, f0, ibf, obf;

  assign liveSts   = {userBits, f1, f0, ibf, obf};
  assign locInData = inBuf;

  always_comb begin
    hostRdata = '0;
    if (strb.rdAct) hostRdata = strb.effAddr ? stsView : outBuf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrShadow   <= '0;
      addrShadow <= 1'b0;
      inBuf      <= '0;
      outBuf     <= '0;
      userBits   <= '0;
      f1         <= 1'b0;
      f0         <= 1'b0;
      ibf        <= 1'b0;
      obf        <= 1'b0;
      stsView    <= '0;
    end else begin
      if (strb.capWr) begin
        wrShadow   <= hostWdata;
        addrShadow <= strb.effAddr;
      end
      if (strb.commitWr) begin
        inBuf <= wrShadow;
        f1    <= addrShadow;
        ibf   <= 1'b1;
      end else if (locInRd) begin
        ibf <= 1'b0;
      end
      if (locOutWr) begin
        outBuf <= locOutData;
        obf    <= 1'b1;
      end else if (strb.commitRdData) begin
        obf <= 1'b0;
      end
      if (locStsWr) userBits <= locStsUser;
      if (locF0Wr)  f0 <= locF0Val;
      if (!strb.stsRead) stsView <= liveSts;
    end
  end

  // R2: a completed host write always leaves the input buffer full
  a_r2_ibf_after_write : assert property (@(posedge clk) disable iff (!rst_n)
    strb.commitWr |=> ibf);

  // R3: local unload empties the input buffer unless a write lands
  a_r3_unload_clears : assert property (@(posedge clk) disable iff (!rst_n)
    (locInRd && !strb.commitWr) |=> !ibf);

  // R4: the end of a host data read empties the output buffer
  a_r4_read_clears_obf : assert property (@(posedge clk) disable iff (!rst_n)
    (strb.commitRdData && !locOutWr) |=> !obf);

  // R5: user status bits follow the local write
  a_r5_user_bits : assert property (@(posedge clk) disable iff (!rst_n)
    locStsWr |=> userBits == $past(locStsUser));

  // R8: host status view holds still during a status read
  a_r8_status_frozen : assert property (@(posedge clk) disable iff (!rst_n)
    (strb.stsRead && $past(strb.stsRead)) |-> $stable(stsView));

  // R7: IBF only rises in the cycle after a strobe ended
  a_r7_ibf_rise_late : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ibf) |-> $past(strb.commitWr));
endmodule

// File: rtl/host_slave_if.sv
module host_slave_if
  import hsi_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int LATCH_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     hostSel,
  input  logic                     hostAddr,
  input  logic                     hostRd,
  input  logic                     hostWr,
  input  logic [DATA_W-1:0]        hostWdata,
  output logic [DATA_W-1:0]        hostRdata,
  output logic                     hostRdEn,
  input  logic                     dmaAck,
  output logic                     pinObf,
  output logic                     pinIbf,
  output logic                     pinDrq,
  input  logic                     locInRd,
  output logic [DATA_W-1:0]        locInData,
  input  logic                     locOutWr,
  input  logic [DATA_W-1:0]        locOutData,
  input  logic                     locStsWr,
  input  logic [DATA_W-FLAG_W-1:0] locStsUser,
  input  logic                     locF0Wr,
  input  logic                     locF0Val,
  input  logic                     locFlagsCmd,
  input  logic                     locDmaCmd,
  input  logic                     locPortWr,
  input  logic [LATCH_W-1:0]       locPortData,
  output logic [DATA_W-1:0]        locStatus
);
  hsiStrobe_t         strb;
  logic               flagsMode, dmaMode, drq;
  logic [LATCH_W-1:0] portLatch;

  hsi_ctrl #(.LATCH_W(LATCH_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .hostSel(hostSel), .hostAddr(hostAddr), .hostRd(hostRd), .hostWr(hostWr),
    .dmaAck(dmaAck), .flagsCmd(locFlagsCmd), .dmaCmd(locDmaCmd),
    .portWr(locPortWr), .portData(locPortData),
    .strb(strb), .flagsMode(flagsMode), .dmaMode(dmaMode), .drq(drq),
    .portLatch(portLatch)
  );

  hsi_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .hostWdata(hostWdata), .hostRdata(hostRdata),
    .locInRd(locInRd), .locInData(locInData),
    .locOutWr(locOutWr), .locOutData(locOutData),
    .locStsWr(locStsWr), .locStsUser(locStsUser),
    .locF0Wr(locF0Wr), .locF0Val(locF0Val),
    .liveSts(locStatus)
  );

  assign hostRdEn = strb.rdAct;
  assign pinObf = flagsMode ? (portLatch[0] & locStatus[OBF_POS])  : portLatch[0];
  assign pinIbf = flagsMode ? (portLatch[1] & ~locStatus[IBF_POS]) : portLatch[1];
  assign pinDrq = dmaMode ? drq : portLatch[2];

  // R6: the bus carries zero whenever it is not driven
  a_r6_idle_bus : assert property (@(posedge clk) disable iff (!rst_n)
    !hostRdEn |-> hostRdata == '0);

  // R9: in flags mode a cleared latch bit holds the pin low
  a_r9_pin_gated : assert property (@(posedge clk) disable iff (!rst_n)
    (flagsMode && !portLatch[0]) |-> !pinObf);
endmodule

// File: tb/host_slave_if_tb_top.sv
module host_slave_if_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hostSel = 0, hostAddr = 0, hostRd = 0, hostWr = 0, dmaAck = 0;
  logic [7:0] hostWdata = 0, locOutData = 0;
  logic [7:0] hostRdata, locInData, locStatus;
  logic hostRdEn, pinObf, pinIbf, pinDrq;
  logic locInRd = 0, locOutWr = 0, locStsWr = 0, locF0Wr = 0, locF0Val = 0;
  logic locFlagsCmd = 0, locDmaCmd = 0, locPortWr = 0;
  logic [3:0] locStsUser = 0;
  logic [2:0] locPortData = 0;

  int total = 0, bad = 0;
  bit finished = 0;
  // bench model of the status byte
  logic [3:0] eUser = 0;
  logic eF1 = 0, eF0 = 0, eIbf = 0, eObf = 0;

  always #5 clk = ~clk;

  host_slave_if dut_i (
    .clk(clk), .rst_n(rst_n), .hostSel(hostSel), .hostAddr(hostAddr),
    .hostRd(hostRd), .hostWr(hostWr), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .hostRdEn(hostRdEn), .dmaAck(dmaAck),
    .pinObf(pinObf), .pinIbf(pinIbf), .pinDrq(pinDrq),
    .locInRd(locInRd), .locInData(locInData), .locOutWr(locOutWr),
    .locOutData(locOutData), .locStsWr(locStsWr), .locStsUser(locStsUser),
    .locF0Wr(locF0Wr), .locF0Val(locF0Val), .locFlagsCmd(locFlagsCmd),
    .locDmaCmd(locDmaCmd), .locPortWr(locPortWr), .locPortData(locPortData),
    .locStatus(locStatus)
  );

  function automatic logic [7:0] expSts();
    return {eUser, eF1, eF0, eIbf, eObf};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic hostWrite(input logic addr, input logic [7:0] data,
                           input logic viaAck, input int hold, input string req);
    step();
    hostSel = !viaAck; dmaAck = viaAck; hostAddr = addr; hostWr = 1; hostWdata = data;
    for (int i = 1; i < hold; i++) begin
      step();
      chk("R7", "status while strobe held", locStatus, expSts());
    end
    step();
    hostWr = 0; hostSel = 0; dmaAck = 0;
    step();
  endtask

  task automatic hostRead(input logic addr, input logic viaAck,
                          output logic [7:0] data, output logic en);
    step();
    hostSel = !viaAck; dmaAck = viaAck; hostAddr = addr; hostRd = 1;
    #1 data = hostRdata; en = hostRdEn;
    step();
    hostRd = 0; hostSel = 0; dmaAck = 0;
    step();
  endtask

  task automatic pulseOut(input logic [7:0] d);
    step(); locOutWr = 1; locOutData = d; step(); locOutWr = 0;
  endtask

  task automatic pulseInRd();
    step(); locInRd = 1; step(); locInRd = 0;
  endtask

  task automatic pulseSts(input logic [3:0] u);
    step(); locStsWr = 1; locStsUser = u; step(); locStsWr = 0;
  endtask

  task automatic pulsePort(input logic [2:0] p);
    step(); locPortWr = 1; locPortData = p; step(); locPortWr = 0;
  endtask

  task automatic t_reset();
    chk("R1", "status", locStatus, 8'h00);
    chk("R1", "bus enable", hostRdEn, 0);
    chk("R1", "pins", {pinObf, pinIbf, pinDrq}, 0);
  endtask

  task automatic t_host_write();
    hostWrite(1'b0, 8'h5A, 1'b0, 3, "R7");
    eIbf = 1; eF1 = 0;
    chk("R2", "input buffer", locInData, 8'h5A);
    chk("R2", "status after data write", locStatus, expSts());
    pulseInRd(); eIbf = 0;
    chk("R3", "ibf after unload", locStatus, expSts());
    hostWrite(1'b1, 8'hC3, 1'b0, 1, "R2");
    eIbf = 1; eF1 = 1;
    chk("R2", "command byte", locInData, 8'hC3);
    chk("R2", "f1 after command", locStatus, expSts());
    pulseInRd(); eIbf = 0;
  endtask

  task automatic t_out_read();
    logic [7:0] d; logic en;
    pulseOut(8'h99); eObf = 1;
    chk("R4", "obf set", locStatus, expSts());
    hostRead(1'b1, 1'b0, d, en);
    chk("R6", "status read", d, expSts());
    chk("R6", "bus enabled", en, 1);
    chk("R4", "obf kept after status read", locStatus[0], 1);
    hostRead(1'b0, 1'b0, d, en);
    chk("R6", "data read", d, 8'h99);
    eObf = 0;
    chk("R4", "obf cleared after data read", locStatus, expSts());
  endtask

  task automatic t_status_bits();
    pulseSts(4'hA); eUser = 4'hA;
    chk("R5", "user bits only", locStatus, expSts());
    step(); locF0Wr = 1; locF0Val = 1; step(); locF0Wr = 0; eF0 = 1;
    chk("R12", "f0 local write", locStatus, expSts());
    hostWrite(1'b0, 8'h00, 1'b0, 1, "R12");
    eIbf = 1; eF1 = 0;
    chk("R12", "f0 after host write", locStatus, expSts());
    pulseInRd(); eIbf = 0;
  endtask

  task automatic t_freeze();
    logic [7:0] v0, d; logic en;
    step();
    hostSel = 1; hostAddr = 1; hostRd = 1;
    #1 v0 = hostRdata;
    chk("R8", "initial view", v0, expSts());
    step(); locStsWr = 1; locStsUser = 4'h3; locOutWr = 1; locOutData = 8'h11;
    step(); locStsWr = 0; locOutWr = 0; eUser = 4'h3; eObf = 1;
    #1 chk("R8", "view frozen 1", hostRdata, v0);
    step();
    chk("R8", "view frozen 2", hostRdata, v0);
    hostRd = 0; hostSel = 0;
    step();
    hostRead(1'b1, 1'b0, d, en);
    chk("R8", "view updated after read", d, expSts());
    hostRead(1'b0, 1'b0, d, en); eObf = 0;
  endtask

  task automatic t_flags();
    pulsePort(3'b001);
    chk("R9", "port mode obf pin", pinObf, 1);
    step(); locFlagsCmd = 1; step(); locFlagsCmd = 0;
    chk("R9", "flag obf pin empty", pinObf, 0);
    pulseOut(8'h22); eObf = 1;
    chk("R9", "flag obf pin full", pinObf, 1);
    pulsePort(3'b010);
    chk("R9", "obf pin gated off", pinObf, 0);
    chk("R9", "ibf pin ready", pinIbf, 1);
    hostWrite(1'b0, 8'h44, 1'b0, 1, "R9"); eIbf = 1;
    chk("R9", "ibf pin busy", pinIbf, 0);
    pulseInRd(); eIbf = 0;
    pulsePort(3'b000);
  endtask

  task automatic t_dma();
    logic [7:0] d; logic en;
    pulsePort(3'b100);
    chk("R10", "port mode drq pin", pinDrq, 1);
    pulsePort(3'b000);
    hostRead(1'b0, 1'b1, d, en);
    chk("R11", "ack ignored read", en, 0);
    hostWrite(1'b0, 8'h77, 1'b1, 1, "R11");
    chk("R11", "ack ignored write", locStatus, expSts());
    step(); locDmaCmd = 1; step(); locDmaCmd = 0;
    chk("R10", "drq low after enable", pinDrq, 0);
    pulsePort(3'b100);
    chk("R10", "drq raised", pinDrq, 1);
    hostWrite(1'b1, 8'h3C, 1'b1, 2, "R11");
    eIbf = 1; eF1 = 0;
    chk("R11", "ack write data", locInData, 8'h3C);
    chk("R11", "ack forces data address", locStatus, expSts());
    chk("R10", "drq cleared by ack write", pinDrq, 0);
    pulseInRd(); eIbf = 0;
    pulsePort(3'b100);
    hostRead(1'b1, 1'b1, d, en);
    chk("R11", "ack read gives out buffer", d, 8'h22);
    chk("R10", "drq cleared by ack read", pinDrq, 0);
    eObf = 0;
    chk("R4", "obf cleared by ack read", locStatus, expSts());
    pulsePort(3'b100);
    step(); locDmaCmd = 1; step(); locDmaCmd = 0;
    chk("R10", "drq cleared by repeat command", pinDrq, 0);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    t_reset();
    t_host_write();
    t_out_read();
    t_status_bits();
    t_freeze();
    t_flags();
    t_dma();
    step();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule